// File: doc/BRIEF.md
# Double-Precision to 48-bit Float Word Converter

This block converts between IEEE 754 double precision values and a compact 48-bit floating-point word. The word holds one sign bit, a 7-bit exponent with bias 64 and a 40-bit fraction with an implied leading one. The word is also laid out as six bytes, with the least significant byte at the lowest offset. The encode path takes a 64-bit double and returns the 48-bit word and its six-byte image. The decode path takes six bytes and rebuilds the double. Each path has its own valid strobe and one register stage.

On encode the block rebiases the exponent and clamps it to the field range. It narrows the mantissa to 40 bits and rounds half up. A rounding carry moves into the exponent. Zero and denormal inputs map to the all-zero word. Infinities and NaNs map to a defined saturated code. On decode the fraction is widened with zero fill and the exponent is rebiased back. Arithmetic and memory access are handled by the logic around the block.

Top module: `flt48_xlate`

## Requirements
- R1: While `rst` is high, every output register clears: both valid outputs are 0, and the word, byte and double outputs are all zero.
- R2: A high valid input gives a high matching valid output exactly one clock later, carrying the converted result. When the valid input is low, the matching valid output is low and the data outputs keep their previous values.
- R3: For a double with an exponent field (bits 62:52) between 1 and 2046, word bit 47 equals double bit 63. Word bits 46:40 hold the unbiased exponent plus 64. Word bits 39:0 hold double mantissa bits 51:12.
- R4: Rounding is half up. When double mantissa bit 11 is 1, one is added to the 40-bit fraction. When bit 11 is 0, lower mantissa bits have no effect.
- R5: If that increment carries out of the 40-bit fraction, the fraction becomes zero and the exponent field goes up by one. An exponent field already at 127 stays at 127.
- R6: An unbiased exponent plus 64 below 0 gives exponent field 0. A value above 127 gives 127. The fraction is formed as in R3/R4 in both cases.
- R7: A double with exponent field 0 (zero of either sign, or a denormal) encodes to the all-zero word.
- R8: A double with exponent field 2047 (infinity or NaN) encodes with bits 46:0 all ones, and bit 47 is the input sign.
- R9: Byte k of a six-byte vector (k = 0 is the lowest offset) carries word bits 8k+7:8k. This holds for the encode output and for the decode input.
- R10: Six zero bytes decode to the double 64'h0.
- R11: A non-zero word decodes as follows: double bit 63 is word bit 47. Double bits 62:52 are the 7-bit exponent field plus 959 (that is, minus 64 plus 1023). Double bits 51:12 are the fraction, and bits 11:0 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_vld_i | input | 1 | Encode request strobe |
| enc_dbl_i | input | 64 | Double to encode |
| dec_vld_i | input | 1 | Decode request strobe |
| dec_bytes_i | input | 6x8 | Six bytes to decode, index = offset |
| enc_vld_o | output | 1 | Encode result valid |
| enc_word_o | output | 48 | Encoded 48-bit word |
| enc_bytes_o | output | 6x8 | Encoded word as six bytes, index = offset |
| dec_vld_o | output | 1 | Decode result valid |
| dec_dbl_o | output | 64 | Decoded double |

## Verification
Some properties are checked on every cycle by the assertions:
- the one-cycle strobe latency, and data outputs that hold while idle;
- sign preservation on finite inputs;
- the all-zero result for zero and denormal exponents, and the all-ones result for infinity/NaN;
- byte-lane order against the word;
- the zero low bits of a decoded mantissa, and the zero result for zero input bytes.

Only the bench's directed scenarios can show the exact numeric results: the rebiased exponent, the half-up rounding, the carry into the exponent with saturation, both clamp limits, and round trips through the byte image.

// File: rtl/flt48_pkg.sv
package flt48_pkg;
  localparam int DBL_W  = 64;
  localparam int DEXP_W = 11;
  localparam int DMAN_W = 52;
  localparam int DBIAS  = 1023;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/flt48_round.sv
module flt48_round #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              half_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [FRAC_W:0] sum;

  always_comb begin
    sum = {1'b0, frac_i} + {{FRAC_W{1'b0}}, half_i};
    if (sum[FRAC_W]) begin
      frac_o = '0;
      exp_o  = (&exp_i) ? exp_i : exp_i + 1'b1;
    end else begin
      frac_o = sum[FRAC_W-1:0];
      exp_o  = exp_i;
    end
  end
endmodule

// File: rtl/flt48_enc_core.sv
module flt48_enc_core
  import flt48_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40,
  parameter int BIAS   = 64,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DBL_W-1:0]  dbl_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SH      = DMAN_W - FRAC_W - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  logic              dsign;
  logic [DEXP_W-1:0] dexp;
  logic [DMAN_W-1:0] dman;
  logic [FRAC_W:0]   top_bits;
  logic [EXP_W-1:0]  exp_clamp;
  logic [EXP_W-1:0]  exp_rnd;
  logic [FRAC_W-1:0] frac_rnd;
  int                biased;

  assign dsign    = dbl_i[DBL_W-1];
  assign dexp     = dbl_i[DBL_W-2 -: DEXP_W];
  assign dman     = dbl_i[DMAN_W-1:0];
  assign top_bits = (FRAC_W+1)'(dman >> SH);

  always_comb begin
    biased = int'(dexp) - DBIAS + BIAS;
    if (biased < 0)             exp_clamp = '0;
    else if (biased > EXP_MAX)  exp_clamp = '1;
    else                        exp_clamp = EXP_W'(biased);
  end

  flt48_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) round_i (
    .exp_i  (exp_clamp),
    .frac_i (top_bits[FRAC_W:1]),
    .half_i (top_bits[0]),
    .exp_o  (exp_rnd),
    .frac_o (frac_rnd)
  );

  always_comb begin
    if (dexp == '0)      word_o = '0;
    else if (&dexp)      word_o = {dsign, {(WORD_W-1){1'b1}}};
    else                 word_o = {dsign, exp_rnd, frac_rnd};
  end
endmodule

// File: rtl/flt48_dec_core.sv
module flt48_dec_core
  import flt48_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40,
  parameter int BIAS   = 64,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [DBL_W-1:0]  dbl_o
);
  localparam int FILL = DMAN_W - FRAC_W;

  logic [EXP_W-1:0]  field;
  logic [DEXP_W-1:0] dexp;

  assign field = word_i[WORD_W-2 -: EXP_W];
  assign dexp  = DEXP_W'(int'(field) + DBIAS - BIAS);

  always_comb begin
    if (word_i == '0) dbl_o = '0;
    else dbl_o = {word_i[WORD_W-1], dexp, word_i[FRAC_W-1:0], {FILL{1'b0}}};
  end
endmodule

// File: rtl/flt48_byte_lane.sv
module flt48_byte_lane
  import flt48_pkg::*;
#(
  parameter int NBYTES = 6,
  localparam int WORD_W = NBYTES * BYTE_W
) (
  input  logic [WORD_W-1:0]             word_i,
  input  logic [NBYTES-1:0][BYTE_W-1:0] bytes_i,
  output logic [NBYTES-1:0][BYTE_W-1:0] bytes_o,
  output logic [WORD_W-1:0]             word_o
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign bytes_o[k]                 = word_i[BYTE_W*k +: BYTE_W];
    assign word_o[BYTE_W*k +: BYTE_W] = bytes_i[k];
  end
endmodule

// File: rtl/flt48_xlate.sv
module flt48_xlate
  import flt48_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40,
  parameter int BIAS   = 64,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int NBYTES = WORD_W / BYTE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enc_vld_i,
  input  logic [DBL_W-1:0]              enc_dbl_i,
  input  logic                          dec_vld_i,
  input  logic [NBYTES-1:0][BYTE_W-1:0] dec_bytes_i,
  output logic                          enc_vld_o,
  output logic [WORD_W-1:0]             enc_word_o,
  output logic [NBYTES-1:0][BYTE_W-1:0] enc_bytes_o,
  output logic                          dec_vld_o,
  output logic [DBL_W-1:0]              dec_dbl_o
);
  logic [WORD_W-1:0]             enc_word_c;
  logic [NBYTES-1:0][BYTE_W-1:0] enc_bytes_c;
  logic [WORD_W-1:0]             dec_word_c;
  logic [DBL_W-1:0]              dec_dbl_c;

  flt48_enc_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) enc_i (
    .dbl_i  (enc_dbl_i),
    .word_o (enc_word_c)
  );

  flt48_byte_lane #(.NBYTES(NBYTES)) lane_i (
    .word_i  (enc_word_c),
    .bytes_i (dec_bytes_i),
    .bytes_o (enc_bytes_c),
    .word_o  (dec_word_c)
  );

  flt48_dec_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) dec_i (
    .word_i (dec_word_c),
    .dbl_o  (dec_dbl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_vld_o   <= 1'b0;
      enc_word_o  <= '0;
      enc_bytes_o <= '0;
    end else begin
      enc_vld_o <= enc_vld_i;
      if (enc_vld_i) begin
        enc_word_o  <= enc_word_c;
        enc_bytes_o <= enc_bytes_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld_o <= 1'b0;
      dec_dbl_o <= '0;
    end else begin
      dec_vld_o <= dec_vld_i;
      if (dec_vld_i) dec_dbl_o <= dec_dbl_c;
    end
  end
endmodule

// File: rtl/flt48_xlate_chk.sv
module flt48_xlate_chk
  import flt48_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int NBYTES = WORD_W / BYTE_W,
  localparam int FILL   = DMAN_W - FRAC_W
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          enc_vld_i,
  input logic [DBL_W-1:0]              enc_dbl_i,
  input logic                          dec_vld_i,
  input logic [NBYTES-1:0][BYTE_W-1:0] dec_bytes_i,
  input logic                          enc_vld_o,
  input logic [WORD_W-1:0]             enc_word_o,
  input logic [NBYTES-1:0][BYTE_W-1:0] enc_bytes_o,
  input logic                          dec_vld_o,
  input logic [DBL_W-1:0]              dec_dbl_o
);
  logic [DEXP_W-1:0] in_exp;
  assign in_exp = enc_dbl_i[DBL_W-2 -: DEXP_W];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!enc_vld_o && !dec_vld_o && enc_word_o == '0 && dec_dbl_o == '0)); // R1

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    enc_vld_i |=> enc_vld_o); // R2

  AST_ENC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enc_vld_i |=> (!enc_vld_o && $stable(enc_word_o))); // R2

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dec_vld_i |=> dec_vld_o); // R2

  AST_DEC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dec_vld_i |=> (!dec_vld_o && $stable(dec_dbl_o))); // R2

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (enc_vld_i && in_exp != '0) |=> enc_word_o[WORD_W-1] == $past(enc_dbl_i[DBL_W-1])); // R3

  AST_ZERO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (enc_vld_i && in_exp == '0) |=> enc_word_o == '0); // R7

  AST_SPECIAL_SAT: assert property (@(posedge clk) disable iff (rst)
    (enc_vld_i && &in_exp) |=> &enc_word_o[WORD_W-2:0]); // R8

  for (genvar k = 0; k < NBYTES; k++) begin : g_order
    AST_BYTE_ORDER: assert property (@(posedge clk) disable iff (rst)
      enc_bytes_o[k] == enc_word_o[BYTE_W*k +: BYTE_W]); // R9
  end

  AST_DEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dec_vld_i && dec_bytes_i == '0) |=> dec_dbl_o == '0); // R10

  AST_DEC_LOW_FILL: assert property (@(posedge clk) disable iff (rst)
    dec_vld_o |-> dec_dbl_o[FILL-1:0] == '0); // R11
endmodule

bind flt48_xlate flt48_xlate_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .enc_vld_i   (enc_vld_i),
  .enc_dbl_i   (enc_dbl_i),
  .dec_vld_i   (dec_vld_i),
  .dec_bytes_i (dec_bytes_i),
  .enc_vld_o   (enc_vld_o),
  .enc_word_o  (enc_word_o),
  .enc_bytes_o (enc_bytes_o),
  .dec_vld_o   (dec_vld_o),
  .dec_dbl_o   (dec_dbl_o)
);

// File: tb/flt48_xlate_tb_top.sv
`timescale 1ns/1ps
module flt48_xlate_tb_top;
  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                enc_vld_i = 1'b0;
  logic [63:0]         enc_dbl_i = '0;
  logic                dec_vld_i = 1'b0;
  logic [5:0][7:0]     dec_bytes_i = '0;
  logic                enc_vld_o;
  logic [47:0]         enc_word_o;
  logic [5:0][7:0]     enc_bytes_o;
  logic                dec_vld_o;
  logic [63:0]         dec_dbl_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  flt48_xlate dut_i (
    .clk(clk), .rst(rst),
    .enc_vld_i(enc_vld_i), .enc_dbl_i(enc_dbl_i),
    .dec_vld_i(dec_vld_i), .dec_bytes_i(dec_bytes_i),
    .enc_vld_o(enc_vld_o), .enc_word_o(enc_word_o), .enc_bytes_o(enc_bytes_o),
    .dec_vld_o(dec_vld_o), .dec_dbl_o(dec_dbl_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc_case(input string req, input logic [63:0] d, input logic [47:0] w);
    @(negedge clk);
    enc_dbl_i = d; enc_vld_i = 1'b1;
    @(negedge clk);
    enc_vld_i = 1'b0;
    check(req, {63'd0, enc_vld_o}, 64'd1);
    check(req, {16'd0, enc_word_o}, {16'd0, w});
    for (int k = 0; k < 6; k++)
      check("R9", {56'd0, enc_bytes_o[k]}, {56'd0, w[8*k +: 8]});
  endtask

  task automatic dec_case(input string req, input logic [47:0] w, input logic [63:0] d);
    @(negedge clk);
    for (int k = 0; k < 6; k++) dec_bytes_i[k] = w[8*k +: 8];
    dec_vld_i = 1'b1;
    @(negedge clk);
    dec_vld_i = 1'b0;
    check(req, {63'd0, dec_vld_o}, 64'd1);
    check(req, dec_dbl_o, d);
  endtask

  task automatic t_reset;
    check("R1", {62'd0, enc_vld_o, dec_vld_o}, 64'd0);
    check("R1", {16'd0, enc_word_o}, 64'd0);
    check("R1", dec_dbl_o, 64'd0);
  endtask

  task automatic t_normal;
    enc_case("R3", 64'h3FF0000000000000, 48'h400000000000);
    enc_case("R3", 64'hC004000000000000, 48'hC14000000000);
  endtask

  task automatic t_round;
    enc_case("R4", 64'h3FF0000000000800, 48'h400000000001);
    enc_case("R4", 64'h3FF00000000007FF, 48'h400000000000);
  endtask

  task automatic t_carry;
    enc_case("R5", 64'h3FFFFFFFFFFFFFFF, 48'h410000000000);
    enc_case("R5", 64'h43EFFFFFFFFFFFFF, 48'h7F0000000000);
  endtask

  task automatic t_clamp;
    enc_case("R6", {1'b0, 11'd2000, 52'h123456789A000}, 48'h7F123456789A);
    enc_case("R6", {1'b1, 11'd100, 52'h0}, 48'h800000000000);
  endtask

  task automatic t_zero;
    enc_case("R7", 64'h0000000000000000, 48'h0);
    enc_case("R3", 64'h3FF0000000000000, 48'h400000000000);
    enc_case("R7", 64'h8000000000000000, 48'h0);
    enc_case("R3", 64'h3FF0000000000000, 48'h400000000000);
    enc_case("R7", 64'h000FFFFFFFFFFFFF, 48'h0);
  endtask

  task automatic t_special;
    enc_case("R8", 64'h7FF0000000000000, 48'h7FFFFFFFFFFF);
    enc_case("R8", 64'hFFF8000000000001, 48'hFFFFFFFFFFFF);
  endtask

  task automatic t_hold;
    enc_case("R2", 64'hC004000000000000, 48'hC14000000000);
    dec_case("R2", 48'h400000000000, 64'h3FF0000000000000);
    @(negedge clk);
    enc_dbl_i = 64'h3FF0000000000000;
    for (int k = 0; k < 6; k++) dec_bytes_i[k] = 8'h00;
    @(negedge clk);
    check("R2", {63'd0, enc_vld_o}, 64'd0);
    check("R2", {16'd0, enc_word_o}, 64'h0000C14000000000);
    check("R2", {63'd0, dec_vld_o}, 64'd0);
    check("R2", dec_dbl_o, 64'h3FF0000000000000);
  endtask

  task automatic t_decode;
    dec_case("R11", 48'hC14000000000, 64'hC004000000000000);
    dec_case("R11", 48'h000000000005, 64'h3BF0000000005000);
    dec_case("R11", 48'hFFFFFFFFFFFF, 64'hC3EFFFFFFFFFF000);
    dec_case("R10", 48'h000000000000, 64'h0);
    dec_case("R9", 48'h0102030405A6, {1'b0, 11'd960, 40'h02030405A6, 12'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_normal();
    t_round();
    t_carry();
    t_clamp();
    t_zero();
    t_special();
    t_hold();
    t_decode();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule